// File: doc/BRIEF.md
# Cascaded converter conversion and readout sequencer

This block sits on the host side of a string of analog-to-digital converters that share one conversion trigger and are wired as a cascade on a single serial data line. On a software start request, or on a tick of an internal pacing timer, it pulses the common convert strobe so that every converter in the string samples at the same instant. It then watches the shared busy flag, first for its rise and then for its fall, and only after the fall does it select the string and run a gated serial clock that idles low. The host samples the data line on each falling clock edge (clock polarity 0, phase 1).

The string delivers one 16-bit word per device, most significant bit first, the device nearest the host first and each further device's word right behind it. The block clocks out exactly enough bits for the configured string length, cuts the stream into words and presents them together with a one-cycle completion pulse. Requests that arrive while a cycle is under way are dropped. An activity output shows whether a cycle is running.

States: `ST_IDLE` (waiting for a trigger), `ST_CONV` (convert strobe high), `ST_WAIT_HI` (waiting for busy to rise), `ST_WAIT_LO` (waiting for busy to fall), `ST_SETUP` (select asserted, clock still low), `ST_SHIFT` (clock running), `ST_HOLD` (select held after the last edge), `ST_DONE` (words published). Transitions: IDLE to CONV on a start request or timer tick; CONV to WAIT_HI after `CNV_W` cycles; WAIT_HI to WAIT_LO when busy is high; WAIT_LO to SETUP when busy is low; SETUP to SHIFT after `HALF_DIV` cycles; SHIFT to HOLD on the last clock edge; HOLD to DONE after `HALF_DIV` cycles; DONE to IDLE unconditionally.

Top module: `chain_conv_reader`

## Requirements
- R1: An accepted trigger raises `cnv_o` for exactly `CNV_W` system cycles (default 2); `cnv_o` only rises when no cycle is active.
- R2: `cs_n_o` goes low only after `busy_i` has been seen high and then low following the convert strobe; `cs_n_o` is never low while `busy_i` is high.
- R3: `sclk_o` is low whenever `cs_n_o` is high, and it is low at the start and at the end of each frame.
- R4: Each high phase and each low phase of `sclk_o` inside a frame lasts exactly `HALF_DIV` system cycles (default 8, giving 15.625 MHz from 250 MHz, under the 17 MHz limit).
- R5: Input data is sampled on the falling edge of `sclk_o`; the converters change `sdi_i` after each rising edge.
- R6: Each frame carries exactly `N_DEV*16` rising edges of `sclk_o` (32 with the default two devices).
- R7: `cs_n_o` falls at least `HALF_DIV` cycles before the first rising edge and rises exactly `HALF_DIV` cycles after the last falling edge.
- R8: Word k occupies `words_o[16k+15:16k]`; word 0 holds the first 16 bits received (the device nearest the host), the first bit of each word being its bit 15.
- R9: `done_o` is high for exactly one cycle, in the same cycle as `words_o` takes the new values; `words_o` then holds until the next `done_o`.
- R10: `active_o` is high from the cycle after an accepted trigger until the cycle after `done_o`; `start_i` pulses while `active_o` is high start nothing.
- R11: While `auto_i` is high the pacing timer triggers a conversion every `TIMER_PERIOD` cycles (default 2000); with `auto_i` low no timer trigger occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled when idle |
| auto_i | input | 1 | Enables the pacing timer |
| busy_i | input | 1 | Shared converter busy flag |
| sdi_i | input | 1 | Serial data from the nearest converter |
| cnv_o | output | 1 | Common convert strobe |
| cs_n_o | output | 1 | Active-low string select |
| sclk_o | output | 1 | Gated serial clock, idles low |
| words_o | output | N_DEV*16 | Assembled result words, word 0 lowest |
| done_o | output | 1 | One-cycle pulse when words_o is updated |
| active_o | output | 1 | High while a conversion/readout cycle runs |

## Verification
Reads are run with alternating-bit words, all-ones against all-zeros and edge-bit patterns, so that a swapped word order, a bit-reversed word or sampling on the wrong clock edge (which shifts every word by one bit) each give a distinct wrong result. One read uses a busy flag that rises several cycles late, which separates waiting for the busy fall from reading as soon as busy is low. Start pulses issued mid-read tell a dropped request from a queued one, and a stretch with the timer enabled then disabled tells pacing from free triggering.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_DONE
    } ccr_state_e;

    function automatic int unsigned ccr_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ccr_sclk_tick.sv
module ccr_sclk_tick #(
    parameter int unsigned HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = ccr_pkg::ccr_max($clog2(HALF_DIV), 1);

    logic [CW-1:0] div_q;
    logic          wrap;

    assign wrap   = (div_q == CW'(HALF_DIV - 1));
    assign tick_o = en_i && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!en_i || wrap) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R4: the divider never runs past its terminal count
    assert_div_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= CW'(HALF_DIV - 1));

endmodule

// File: rtl/ccr_pace_timer.sv
module ccr_pace_timer #(
    parameter int unsigned PERIOD = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic fire_o
);
    generate
        if (PERIOD == 0) begin : g_off
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ run_i;
            assign fire_o    = 1'b0;
        end else begin : g_on
            localparam int unsigned TW = ccr_pkg::ccr_max($clog2(PERIOD), 1);
            logic [TW-1:0] tmr_q;
            logic          last;

            assign last   = (tmr_q == TW'(PERIOD - 1));
            assign fire_o = run_i && last;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tmr_q <= '0;
                end else if (!run_i || last) begin
                    tmr_q <= '0;
                end else begin
                    tmr_q <= tmr_q + 1'b1;
                end
            end

            // R11: no timer trigger while the timer is disabled
            assert_timer_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !run_i |=> (tmr_q == '0));
        end
    endgenerate

endmodule

// File: rtl/ccr_deser.sv
module ccr_deser #(
    parameter int unsigned N_DEV  = 2,
    parameter int unsigned WORD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_i,
    input  logic                    bit_i,
    input  logic                    load_i,
    output logic [N_DEV*WORD_W-1:0] words_o
);
    localparam int unsigned TOTAL = N_DEV * WORD_W;
    localparam int unsigned BW    = $clog2(TOTAL + 1);

    logic [TOTAL-1:0]        sr_q;
    logic [BW-1:0]           bit_cnt_q;
    logic [N_DEV*WORD_W-1:0] split;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= {sr_q[TOTAL-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if (load_i) begin
            bit_cnt_q <= '0;
        end else if (shift_i) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // First-received word sits at the top of the shift register.
    generate
        for (genvar g = 0; g < N_DEV; g++) begin : g_split
            assign split[g*WORD_W +: WORD_W] = sr_q[TOTAL-1-g*WORD_W -: WORD_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_o <= '0;
        end else if (load_i) begin
            words_o <= split;
        end
    end

    // R6: never more bits than the chain holds
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> (bit_cnt_q < BW'(TOTAL)));

    // R6: words are published only once the whole chain has been shifted in
    assert_full_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (bit_cnt_q == BW'(TOTAL)));

endmodule

// File: rtl/chain_conv_reader.sv
module chain_conv_reader #(
    parameter int unsigned N_DEV        = 2,
    parameter int unsigned WORD_W       = 16,
    parameter int unsigned HALF_DIV     = 8,
    parameter int unsigned CNV_W        = 2,
    parameter int unsigned TIMER_PERIOD = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    auto_i,
    input  logic                    busy_i,
    input  logic                    sdi_i,
    output logic                    cnv_o,
    output logic                    cs_n_o,
    output logic                    sclk_o,
    output logic [N_DEV*WORD_W-1:0] words_o,
    output logic                    done_o,
    output logic                    active_o
);
    import ccr_pkg::*;

    localparam int unsigned TOTAL = N_DEV * WORD_W;
    localparam int unsigned EDGES = 2 * TOTAL;
    localparam int unsigned EW    = $clog2(EDGES + 1);
    localparam int unsigned CW    = ccr_max($clog2(ccr_max(CNV_W, HALF_DIV) + 1), 1);

    ccr_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [EW-1:0]  edge_q;
    logic           sclk_q;
    logic           tick;
    logic           fire;
    logic           trig;
    logic           last_edge;
    logic           sample;

    ccr_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q == ST_SHIFT),
        .tick_o (tick)
    );

    ccr_pace_timer #(.PERIOD(TIMER_PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (auto_i),
        .fire_o (fire)
    );

    assign trig      = start_i || fire;
    assign last_edge = tick && (edge_q == EW'(EDGES - 1));
    assign sample    = (state_q == ST_SHIFT) && tick && sclk_q;

    ccr_deser #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sample),
        .bit_i   (sdi_i),
        .load_i  (state_d == ST_DONE),
        .words_o (words_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig)                         state_d = ST_CONV;
            ST_CONV:    if (cnt_q == CW'(CNV_W - 1))      state_d = ST_WAIT_HI;
            ST_WAIT_HI: if (busy_i)                       state_d = ST_WAIT_LO;
            ST_WAIT_LO: if (!busy_i)                      state_d = ST_SETUP;
            ST_SETUP:   if (cnt_q == CW'(HALF_DIV - 1))   state_d = ST_SHIFT;
            ST_SHIFT:   if (last_edge)                    state_d = ST_HOLD;
            ST_HOLD:    if (cnt_q == CW'(HALF_DIV - 1))   state_d = ST_DONE;
            ST_DONE:                                      state_d = ST_IDLE;
            default:                                      state_d = ST_IDLE;
        endcase
    end

    // Dwell counter, restarted on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Serial clock edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else if (state_q != ST_SHIFT) begin
            edge_q <= '0;
        end else if (tick) begin
            edge_q <= edge_q + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_o    <= 1'b0;
            cs_n_o   <= 1'b1;
            done_o   <= 1'b0;
            active_o <= 1'b0;
            sclk_q   <= 1'b0;
        end else begin
            cnv_o    <= (state_d == ST_CONV);
            cs_n_o   <= !((state_d == ST_SETUP) || (state_d == ST_SHIFT) || (state_d == ST_HOLD));
            done_o   <= (state_d == ST_DONE);
            active_o <= (state_d != ST_IDLE);
            if (state_q != ST_SHIFT) begin
                sclk_q <= 1'b0;
            end else if (tick) begin
                sclk_q <= !sclk_q;
            end
        end
    end

    assign sclk_o = sclk_q;

    // R3: the clock is parked low whenever the string is deselected
    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R2: selection only follows a sampled low busy flag
    assert_cs_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !$past(busy_i));

    // R1 / R10: a convert strobe never starts during an active cycle
    assert_cnv_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> !$past(active_o));

    // R9: completion is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the edge counter never passes the frame length
    assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (edge_q < EW'(EDGES)));

    // R1: strobe and selection never overlap
    assert_cnv_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> cs_n_o);

endmodule

// File: tb/chain_conv_reader_tb_top.sv
`timescale 1ns/1ps
module chain_conv_reader_tb_top;

    localparam int N_DEV  = 2;
    localparam int WORD_W = 16;
    localparam int HALF   = 8;
    localparam int CNVW   = 2;
    localparam int TPER   = 2000;
    localparam int TOTAL  = N_DEV * WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic auto_i = 1'b0;
    logic busy_i = 1'b0;
    logic sdi_i = 1'b0;
    logic cnv_o, cs_n_o, sclk_o, done_o, active_o;
    logic [N_DEV*WORD_W-1:0] words_o;

    always #2 clk = ~clk;

    chain_conv_reader #(
        .N_DEV(N_DEV), .WORD_W(WORD_W), .HALF_DIV(HALF), .CNV_W(CNVW), .TIMER_PERIOD(TPER)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_i(auto_i), .busy_i(busy_i),
        .sdi_i(sdi_i), .cnv_o(cnv_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .words_o(words_o), .done_o(done_o), .active_o(active_o)
    );

    int n_checks = 0;
    int n_errors = 0;

    // converter string model state
    logic [15:0] dw0 = 16'h0, dw1 = 16'h0;
    int busy_dly = 0;
    int busy_len = 60;
    int dly_cnt = -1, len_cnt = 0;
    int ptr = 0;
    logic seen_busy = 1'b0;

    // monitor state
    logic sclk_p = 1'b0, cs_p = 1'b1, cnv_p = 1'b0, done_p = 1'b0;
    int hi_run = 0, lo_run = 0, rises = 0, since_cs = 0, since_fall = 0, cnv_run = 0, done_run = 0;
    int v_busy = 0, v_idle = 0, v_phase = 0, v_count = 0, v_setup = 0, v_hold = 0, v_cnv = 0, v_done = 0;
    int n_cnv = 0, n_done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        // busy model
        if (cnv_o && !cnv_p) begin
            n_cnv++;
            seen_busy = 1'b0;
            dly_cnt = busy_dly;
        end
        if (dly_cnt == 0) begin
            busy_i = 1'b1;
            len_cnt = busy_len;
            dly_cnt = -1;
        end else if (dly_cnt > 0) begin
            dly_cnt--;
        end else if (len_cnt > 0) begin
            len_cnt--;
            if (len_cnt == 0) busy_i = 1'b0;
        end
        if (busy_i) seen_busy = 1'b1;

        // R1 strobe width
        if (cnv_o) cnv_run++;
        if (!cnv_o && cnv_p) begin
            if (cnv_run != CNVW) v_cnv++;
            cnv_run = 0;
        end

        // R2 / R3
        if (!cs_n_o && (busy_i || !seen_busy)) v_busy++;
        if (cs_n_o && sclk_o) v_idle++;

        // frame start
        if (!cs_n_o && cs_p) begin
            ptr = TOTAL - 1;
            rises = 0;
            since_cs = 0;
        end else begin
            since_cs++;
        end

        // clock edges and data model (data changes after each rising edge)
        if (sclk_o && !sclk_p) begin
            if (rises == 0) begin
                if (since_cs < HALF) v_setup++;
            end else if (lo_run != HALF) begin
                v_phase++;
            end
            rises++;
            hi_run = 1;
            if (ptr >= 0) begin
                sdi_i = (ptr >= 16) ? dw0[ptr-16] : dw1[ptr];
                ptr--;
            end
        end else if (sclk_o) begin
            hi_run++;
        end
        if (!sclk_o && sclk_p) begin
            if (hi_run != HALF) v_phase++;
            lo_run = 1;
            since_fall = 0;
        end else begin
            if (!sclk_o) lo_run++;
            since_fall++;
        end

        // frame end
        if (cs_n_o && !cs_p) begin
            if (rises != TOTAL) v_count++;
            if (since_fall != HALF) v_hold++;
        end

        // completion
        if (done_o) begin
            done_run++;
            if (!done_p) n_done++;
        end else begin
            if (done_p && done_run != 1) v_done++;
            done_run = 0;
        end

        sclk_p = sclk_o;
        cs_p   = cs_n_o;
        cnv_p  = cnv_o;
        done_p = done_o;
    end

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        #1;
        chk(cs_n_o == 1'b1, "R3 reset cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R3 reset sclk", sclk_o, 0);
        chk(cnv_o == 1'b0, "R1 reset cnv", cnv_o, 0);
        chk(done_o == 1'b0, "R9 reset done", done_o, 0);
        chk(active_o == 1'b0, "R10 reset active", active_o, 0);
        chk(words_o == '0, "R8 reset words", words_o, 0);
    endtask

    task automatic t_read(input logic [15:0] a, input logic [15:0] b, input int dly);
        bit seen;
        int vb;
        dw0 = a; dw1 = b; busy_dly = dly;
        vb = v_busy;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(active_o == 1'b1, "R10 active after start", active_o, 1);
        wait_done(seen);
        chk(seen, "R9 done seen", seen, 1);
        chk(words_o[15:0] == a, "R8 R5 word0 nearest", words_o[15:0], a);
        chk(words_o[31:16] == b, "R8 R5 word1 upstream", words_o[31:16], b);
        @(negedge clk);
        chk(active_o == 1'b0, "R10 idle after done", active_o, 0);
        chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        chk(v_busy == vb, "R2 cs vs busy", v_busy - vb, 0);
    endtask

    task automatic t_frame_shape();
        chk(v_cnv == 0, "R1 strobe width", v_cnv, 0);
        chk(v_idle == 0, "R3 clock idle low", v_idle, 0);
        chk(v_phase == 0, "R4 half-period length", v_phase, 0);
        chk(v_count == 0, "R6 edges per frame", v_count, 0);
        chk(v_setup == 0, "R7 select setup", v_setup, 0);
        chk(v_hold == 0, "R7 select hold", v_hold, 0);
        chk(v_done == 0, "R9 done width", v_done, 0);
    endtask

    task automatic t_hold_words();
        logic [31:0] snap;
        snap = words_o;
        repeat (300) @(negedge clk);
        chk(words_o == snap, "R9 words hold", words_o, snap);
    endtask

    task automatic t_ignore();
        int c0, d0;
        bit seen;
        c0 = n_cnv; d0 = n_done;
        dw0 = 16'h1234; dw1 = 16'hFEDC; busy_dly = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (150) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        wait_done(seen);
        repeat (1500) @(negedge clk);
        chk(n_cnv - c0 == 1, "R10 extra starts ignored (cnv)", n_cnv - c0, 1);
        chk(n_done - d0 == 1, "R10 extra starts ignored (done)", n_done - d0, 1);
        chk(words_o == {16'hFEDC, 16'h1234}, "R8 words after ignored starts", words_o, {16'hFEDC, 16'h1234});
    endtask

    task automatic t_timer();
        int d0;
        dw0 = 16'h5A5A; dw1 = 16'h0F0F; busy_dly = 0;
        d0 = n_done;
        @(negedge clk) auto_i = 1'b1;
        repeat (TPER * 2 + 1000) @(negedge clk);
        chk(n_done - d0 == 2, "R11 timer paced reads", n_done - d0, 2);
        chk(words_o == {16'h0F0F, 16'h5A5A}, "R11 timer read data", words_o, {16'h0F0F, 16'h5A5A});
        auto_i = 1'b0;
        d0 = n_done;
        repeat (TPER * 2) @(negedge clk);
        chk(n_done - d0 == 0, "R11 timer off", n_done - d0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_read(16'hA5C3, 16'h3C5A, 0);
        t_hold_words();
        t_read(16'hFFFF, 16'h0000, 0);
        t_read(16'h8001, 16'h7FFE, 6);
        t_read(16'h0001, 16'h8000, 3);
        t_ignore();
        t_timer();
        t_frame_shape();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule